// File: doc/BRIEF.md
# Prefetch Read Request Generator

This block sits on the upstream side of a bridge and turns one accepted read request into the read the target side should issue: how many Dwords to fetch, the aligned address at which fetching must stop, and whether the target read is offered as a 64-bit transfer. The stop address depends on three things together: the read command, whether the address lies in a prefetchable range, and whether the bridge is in flow-through mode. Lines are sized by the initiator-side cache line size, which arrives with each request.

The 64-bit qualifier is chosen only from the quadword alignment of the start address. How close the address is to a line or page boundary plays no part. Each result is handed over through a valid/ready pair. When the target later reports that a 64-bit offer was refused, the block names the upper Dword that still has to be fetched by a separate single-Dword read.

Top module: `prefetch_req_gen`

## Requirements
- R1: `rsp_req64` is 1 exactly when bits [2:0] of the request address are zero, even when the stop address is only two Dwords away.
- R2: `req_cls` values 8, 16 and 32 select lines of 32, 64 and 128 bytes. Every other value is handled as 8.
- R3: Outside flow-through mode, a plain read (command 2'b00) to a non-prefetchable range fetches 1 Dword, and its limit is the Dword-aligned start plus 4.
- R4: Outside flow-through mode, a plain read to a prefetchable range and a read-line command (2'b01) in either range stop at the end of the aligned cache line holding the start address.
- R5: Outside flow-through mode, a read-multiple command (2'b10) stops at the end of the aligned line that follows the start line, in either range.
- R6: In flow-through mode (`req_flow`=1) the limit is the next 4 KB boundary, whatever the command and range. When `req_win`=1 the limit is instead the next 2^`req_page_shift` byte boundary, with the shift clamped to the range 12 to 20.
- R7: `rsp_dwords` = (limit − Dword-aligned start)/4, computed modulo 2^32 so that a limit wrapping to 0 is handled. The count is never 0.
- R8: The reserved command 2'b11 behaves as a plain read.
- R9: A request is taken when `req_valid` is high and (`rsp_valid` is low or `rsp_ready` is high). Its result appears with `rsp_valid` on the next cycle and stays stable while `rsp_ready` is low.
- R10: A result is armed when it is handed over with `rsp_req64`=1. In a cycle with `ack_valid`=1 and `ack64`=0 while a result is armed, the next cycle gives a one-cycle `refetch_valid` with `refetch_addr` = the armed Dword-aligned start plus 4. When `ack64`=1, or when nothing is armed, no refetch is signalled.
- R11: An acknowledge report in the same cycle as the hand-over of a newer 64-bit result resolves the older one. The newer result stays armed for the next report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 32 | Byte start address |
| req_cmd | input | 2 | 00 plain read, 01 read line, 10 read multiple, 11 reserved |
| req_pref | input | 1 | Address lies in a prefetchable range |
| req_flow | input | 1 | Flow-through mode |
| req_win | input | 1 | Address lies in the special upstream paged window |
| req_page_shift | input | 5 | log2 of the window page size in bytes |
| req_cls | input | 8 | Initiator-side cache line size in Dwords |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_dwords | output | 30 | Dwords to fetch |
| rsp_limit | output | 32 | Aligned stop address |
| rsp_req64 | output | 1 | Offer the target read as 64-bit |
| ack_valid | input | 1 | Target reports its 64-bit acknowledge |
| ack64 | input | 1 | Target accepted the 64-bit offer |
| refetch_valid | output | 1 | Upper Dword must be fetched separately |
| refetch_addr | output | 32 | Address of that upper Dword |

## Verification
Two functions can fall in the same cycle: the hand-over of a new 64-bit result and the target's acknowledge report for the previous one. The bench provokes this by stalling a second 64-bit result with `rsp_ready` low, then releasing it in the very cycle that a refused acknowledge arrives for the first. The refetch address that follows must name the first request's upper Dword. A second refused report must then name the second request's upper Dword.

// File: rtl/prefetch_req_pkg.sv
package prefetch_req_pkg;

    localparam int unsigned PFR_ADDR_W = 32;
    localparam int unsigned PFR_CNT_W  = PFR_ADDR_W - 2;
    localparam int unsigned PFR_SH_W   = 5;

    typedef enum logic [1:0] {
        CMD_MEM_RD  = 2'b00,
        CMD_RD_LINE = 2'b01,
        CMD_RD_MULT = 2'b10,
        CMD_RSVD    = 2'b11
    } rd_cmd_e;

    typedef struct packed {
        logic [PFR_ADDR_W-1:0] addr;
        rd_cmd_e               cmd;
        logic                  pref;
        logic                  flow;
        logic                  win;
        logic [PFR_SH_W-1:0]   page_shift;
    } pf_req_t;

    typedef struct packed {
        logic [PFR_ADDR_W-1:0] base;
        logic [PFR_ADDR_W-1:0] limit;
        logic [PFR_CNT_W-1:0]  dwords;
        logic                  req64;
    } pf_res_t;

    // Next boundary of 2^sh bytes strictly above addr (wraps modulo 2^ADDR_W).
    function automatic logic [PFR_ADDR_W-1:0] align_up(
        input logic [PFR_ADDR_W-1:0] addr,
        input logic [PFR_SH_W-1:0]   sh,
        input logic [1:0]            steps
    );
        logic [PFR_ADDR_W-1:0] idx;
        idx = (addr >> sh) + PFR_ADDR_W'(steps);
        return idx << sh;
    endfunction

    function automatic logic [PFR_SH_W-1:0] clamp_shift(
        input logic [PFR_SH_W-1:0] sh,
        input logic [PFR_SH_W-1:0] lo,
        input logic [PFR_SH_W-1:0] hi
    );
        if (sh < lo) return lo;
        if (sh > hi) return hi;
        return sh;
    endfunction

endpackage

// File: rtl/pfr_line_decode.sv
module pfr_line_decode
    import prefetch_req_pkg::*;
#(
    parameter int unsigned CLS_W     = 8,
    parameter int unsigned MIN_CLS   = 8,
    parameter int unsigned N_SIZES   = 3,
    parameter int unsigned MIN_SHIFT = 5
) (
    input  logic [CLS_W-1:0]    cls,
    output logic [PFR_SH_W-1:0] line_shift
);
    logic [N_SIZES-1:0] hit;

    for (genvar i = 0; i < N_SIZES; i++) begin : g_size
        assign hit[i] = (cls == CLS_W'(MIN_CLS << i));
    end

    always_comb begin
        line_shift = PFR_SH_W'(MIN_SHIFT);
        for (int k = 0; k < int'(N_SIZES); k++) begin
            if (hit[k]) line_shift = PFR_SH_W'(MIN_SHIFT + k);
        end
    end
endmodule

// File: rtl/pfr_boundary_calc.sv
module pfr_boundary_calc
    import prefetch_req_pkg::*;
#(
    parameter int unsigned FLOW_SHIFT = 12,
    parameter int unsigned PAGE_MIN   = 12,
    parameter int unsigned PAGE_MAX   = 20
) (
    input  pf_req_t             req,
    input  logic [PFR_SH_W-1:0] line_shift,
    output pf_res_t             res
);
    logic [PFR_ADDR_W-1:0] base;
    logic [PFR_ADDR_W-1:0] limit;
    logic [PFR_SH_W-1:0]   flow_sh;

    assign base = {req.addr[PFR_ADDR_W-1:2], 2'b00};

    always_comb begin
        if (req.win)
            flow_sh = clamp_shift(req.page_shift, PFR_SH_W'(PAGE_MIN), PFR_SH_W'(PAGE_MAX));
        else
            flow_sh = PFR_SH_W'(FLOW_SHIFT);
    end

    always_comb begin
        if (req.flow) begin
            limit = align_up(base, flow_sh, 2'd1);
        end else begin
            unique case (req.cmd)
                CMD_RD_LINE: limit = align_up(base, line_shift, 2'd1);
                CMD_RD_MULT: limit = align_up(base, line_shift, 2'd2);
                default: begin
                    if (req.pref) limit = align_up(base, line_shift, 2'd1);
                    else          limit = base + PFR_ADDR_W'(4);
                end
            endcase
        end
    end

    always_comb begin
        res.base   = base;
        res.limit  = limit;
        res.dwords = PFR_CNT_W'((limit - base) >> 2);
        res.req64  = (req.addr[2:0] == 3'b000);
    end
endmodule

// File: rtl/pfr_result_stage.sv
module pfr_result_stage
    import prefetch_req_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    output logic    in_ready,
    input  pf_res_t in_res,
    output logic    out_valid,
    input  logic    out_ready,
    output pf_res_t out_res
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) out_res <= in_res;
        end
    end
endmodule

// File: rtl/pfr_refetch_track.sv
module pfr_refetch_track
    import prefetch_req_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  hand_fire,
    input  logic                  hand_req64,
    input  logic [PFR_ADDR_W-1:0] hand_base,
    input  logic                  ack_valid,
    input  logic                  ack64,
    output logic                  refetch_valid,
    output logic [PFR_ADDR_W-1:0] refetch_addr
);
    logic                  armed;
    logic [PFR_ADDR_W-1:0] armed_base;
    logic                  refused;

    assign refused = ack_valid && armed && !ack64;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed         <= 1'b0;
            armed_base    <= '0;
            refetch_valid <= 1'b0;
            refetch_addr  <= '0;
        end else begin
            refetch_valid <= refused;
            if (refused) refetch_addr <= armed_base + PFR_ADDR_W'(4);
            if (hand_fire) begin
                armed      <= hand_req64;
                armed_base <= hand_base;
            end else if (ack_valid) begin
                armed <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/prefetch_req_gen.sv
module prefetch_req_gen
    import prefetch_req_pkg::*;
#(
    parameter int unsigned CLS_W      = 8,
    parameter int unsigned FLOW_SHIFT = 12,
    parameter int unsigned PAGE_MIN   = 12,
    parameter int unsigned PAGE_MAX   = 20
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [PFR_ADDR_W-1:0] req_addr,
    input  logic [1:0]            req_cmd,
    input  logic                  req_pref,
    input  logic                  req_flow,
    input  logic                  req_win,
    input  logic [PFR_SH_W-1:0]   req_page_shift,
    input  logic [CLS_W-1:0]      req_cls,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [PFR_CNT_W-1:0]  rsp_dwords,
    output logic [PFR_ADDR_W-1:0] rsp_limit,
    output logic                  rsp_req64,
    input  logic                  ack_valid,
    input  logic                  ack64,
    output logic                  refetch_valid,
    output logic [PFR_ADDR_W-1:0] refetch_addr
);
    pf_req_t             req_s;
    pf_res_t             calc_res;
    pf_res_t             held_res;
    logic [PFR_SH_W-1:0] line_shift;

    always_comb begin
        req_s.addr       = req_addr;
        req_s.cmd        = rd_cmd_e'(req_cmd);
        req_s.pref       = req_pref;
        req_s.flow       = req_flow;
        req_s.win        = req_win;
        req_s.page_shift = req_page_shift;
    end

    pfr_line_decode #(.CLS_W(CLS_W)) u_line (
        .cls        (req_cls),
        .line_shift (line_shift)
    );

    pfr_boundary_calc #(
        .FLOW_SHIFT (FLOW_SHIFT),
        .PAGE_MIN   (PAGE_MIN),
        .PAGE_MAX   (PAGE_MAX)
    ) u_calc (
        .req        (req_s),
        .line_shift (line_shift),
        .res        (calc_res)
    );

    pfr_result_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_ready  (req_ready),
        .in_res    (calc_res),
        .out_valid (rsp_valid),
        .out_ready (rsp_ready),
        .out_res   (held_res)
    );

    assign rsp_dwords = held_res.dwords;
    assign rsp_limit  = held_res.limit;
    assign rsp_req64  = held_res.req64;

    pfr_refetch_track u_track (
        .clk           (clk),
        .rst           (rst),
        .hand_fire     (rsp_valid && rsp_ready),
        .hand_req64    (held_res.req64),
        .hand_base     (held_res.base),
        .ack_valid     (ack_valid),
        .ack64         (ack64),
        .refetch_valid (refetch_valid),
        .refetch_addr  (refetch_addr)
    );
endmodule

// File: rtl/prefetch_req_gen_chk.sv
module prefetch_req_gen_chk
    import prefetch_req_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic [PFR_ADDR_W-1:0] req_addr,
    input logic [1:0]            req_cmd,
    input logic                  req_pref,
    input logic                  req_flow,
    input logic                  req_win,
    input logic                  rsp_valid,
    input logic                  rsp_ready,
    input logic [PFR_CNT_W-1:0]  rsp_dwords,
    input logic [PFR_ADDR_W-1:0] rsp_limit,
    input logic                  rsp_req64,
    input logic                  ack_valid,
    input logic                  ack64,
    input logic                  refetch_valid
);
    logic take;
    assign take = req_valid && req_ready;

    a_r1_req64_from_align: assert property (@(posedge clk) disable iff (rst)
        take |=> (rsp_valid && rsp_req64 == ($past(req_addr[2:0]) == 3'b000)));

    a_r3_single_dword: assert property (@(posedge clk) disable iff (rst)
        (take && req_cmd == 2'b00 && !req_pref && !req_flow) |=> (rsp_dwords == PFR_CNT_W'(1)));

    a_r6_flow_4k: assert property (@(posedge clk) disable iff (rst)
        (take && req_flow && !req_win) |=> (rsp_limit[11:0] == 12'h000));

    a_r7_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_dwords != '0));

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_dwords)
                                       && $stable(rsp_limit) && $stable(rsp_req64)));

    a_r10_refetch_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(refetch_valid) |-> $past(ack_valid && !ack64));
endmodule

bind prefetch_req_gen prefetch_req_gen_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_cmd       (req_cmd),
    .req_pref      (req_pref),
    .req_flow      (req_flow),
    .req_win       (req_win),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_dwords    (rsp_dwords),
    .rsp_limit     (rsp_limit),
    .rsp_req64     (rsp_req64),
    .ack_valid     (ack_valid),
    .ack64         (ack64),
    .refetch_valid (refetch_valid)
);

// File: tb/prefetch_req_gen_tb_top.sv
module prefetch_req_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_cmd = '0;
    logic        req_pref = 1'b0;
    logic        req_flow = 1'b0;
    logic        req_win = 1'b0;
    logic [4:0]  req_page_shift = '0;
    logic [7:0]  req_cls = 8'd8;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [29:0] rsp_dwords;
    logic [31:0] rsp_limit;
    logic        rsp_req64;
    logic        ack_valid = 1'b0;
    logic        ack64 = 1'b0;
    logic        refetch_valid;
    logic [31:0] refetch_addr;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    prefetch_req_gen dut_i (.*);

    typedef struct packed {
        logic [3:0]  rq;
        logic [31:0] addr;
        logic [1:0]  cmd;
        logic        pref;
        logic        flow;
        logic        win;
        logic [4:0]  psh;
        logic [7:0]  cls;
        logic [29:0] dw;
        logic [31:0] lim;
        logic        r64;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 32'h0000_1000, 2'b00, 1'b0, 1'b0, 1'b0, 5'd0,  8'd16, 30'd1,       32'h0000_1004, 1'b1}, // R3
        '{4'd3, 32'h0000_1004, 2'b00, 1'b0, 1'b0, 1'b0, 5'd0,  8'd16, 30'd1,       32'h0000_1008, 1'b0}, // R3 R1
        '{4'd4, 32'h0000_1008, 2'b00, 1'b1, 1'b0, 1'b0, 5'd0,  8'd16, 30'd14,      32'h0000_1040, 1'b1}, // R4
        '{4'd1, 32'h0000_1038, 2'b01, 1'b0, 1'b0, 1'b0, 5'd0,  8'd16, 30'd2,       32'h0000_1040, 1'b1}, // R1 two Dwords left
        '{4'd5, 32'h0000_1010, 2'b10, 1'b0, 1'b0, 1'b0, 5'd0,  8'd8,  30'd12,      32'h0000_1040, 1'b1}, // R5
        '{4'd5, 32'h0000_1024, 2'b10, 1'b1, 1'b0, 1'b0, 5'd0,  8'd32, 30'd55,      32'h0000_1100, 1'b0}, // R5 R2
        '{4'd2, 32'h0000_1024, 2'b01, 1'b0, 1'b0, 1'b0, 5'd0,  8'd12, 30'd7,       32'h0000_1040, 1'b0}, // R2 odd size
        '{4'd6, 32'h0000_2FF0, 2'b00, 1'b0, 1'b1, 1'b0, 5'd0,  8'd16, 30'd4,       32'h0000_3000, 1'b1}, // R6 4KB
        '{4'd6, 32'h0001_2340, 2'b01, 1'b1, 1'b1, 1'b1, 5'd16, 8'd16, 30'h3730,    32'h0002_0000, 1'b1}, // R6 page
        '{4'd6, 32'h0000_5000, 2'b10, 1'b0, 1'b1, 1'b0, 5'd16, 8'd8,  30'd1024,    32'h0000_6000, 1'b1}, // R6
        '{4'd8, 32'h0000_100C, 2'b11, 1'b0, 1'b0, 1'b0, 5'd0,  8'd16, 30'd1,       32'h0000_1010, 1'b0}, // R8
        '{4'd7, 32'hFFFF_FFF8, 2'b01, 1'b0, 1'b0, 1'b0, 5'd0,  8'd8,  30'd2,       32'h0000_0000, 1'b1}, // R7 wrap
        '{4'd1, 32'h0000_1002, 2'b00, 1'b0, 1'b0, 1'b0, 5'd0,  8'd16, 30'd1,       32'h0000_1004, 1'b0}, // R1
        '{4'd6, 32'h0000_3100, 2'b00, 1'b1, 1'b1, 1'b1, 5'd5,  8'd16, 30'd960,     32'h0000_4000, 1'b1}, // R6 clamp low
        '{4'd6, 32'h0001_2340, 2'b00, 1'b1, 1'b1, 1'b1, 5'd25, 8'd16, 30'h3B730,   32'h0010_0000, 1'b1}  // R6 clamp high
    };

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_addr = v.addr; req_cmd = v.cmd; req_pref = v.pref; req_flow = v.flow;
        req_win = v.win; req_page_shift = v.psh; req_cls = v.cls;
    endtask

    // Presents one request at a negedge; returns at the negedge after it is taken.
    task automatic send(input vec_t v, input bit ready_val);
        @(negedge clk);
        drive(v);
        req_valid = 1'b1;
        rsp_ready = ready_val;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_rsp(input vec_t v, input int idx);
        chk(rsp_valid == 1'b1, $sformatf("R9 valid vec%0d", idx), 64'(rsp_valid), 64'd1);
        chk(rsp_dwords == v.dw, $sformatf("R7 R%0d dwords vec%0d", v.rq, idx), 64'(rsp_dwords), 64'(v.dw));
        chk(rsp_limit == v.lim, $sformatf("R%0d limit vec%0d", v.rq, idx), 64'(rsp_limit), 64'(v.lim));
        chk(rsp_req64 == v.r64, $sformatf("R1 req64 vec%0d", idx), 64'(rsp_req64), 64'(v.r64));
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        vec_t va, vb;
        repeat (3) @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk(refetch_valid == 1'b0, "R10 reset refetch_valid", 64'(refetch_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'd1);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i], 1'b1);
            check_rsp(VECS[i], i);
        end

        // R9: back-pressure holds the result and blocks a new request
        send(VECS[2], 1'b0);
        check_rsp(VECS[2], 100);
        @(negedge clk);
        drive(VECS[4]);
        req_valid = 1'b1;
        chk(req_ready == 1'b0, "R9 not ready when stalled", 64'(req_ready), 64'd0);
        repeat (2) @(negedge clk);
        check_rsp(VECS[2], 101);
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(VECS[4], 102);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 drained", 64'(rsp_valid), 64'd0);

        // R10: refused 64-bit offer -> refetch of upper Dword
        send(VECS[2], 1'b1);          // start 0x1008, req64
        @(negedge clk);               // handed over at the previous edge
        ack_valid = 1'b1; ack64 = 1'b0;
        @(negedge clk);
        ack_valid = 1'b0;
        chk(refetch_valid == 1'b1, "R10 refetch raised", 64'(refetch_valid), 64'd1);
        chk(refetch_addr == 32'h0000_100C, "R10 refetch addr", 64'(refetch_addr), 64'h100C);
        @(negedge clk);
        chk(refetch_valid == 1'b0, "R10 one-cycle pulse", 64'(refetch_valid), 64'd0);

        // R10: accepted offer -> no refetch
        send(VECS[7], 1'b1);
        @(negedge clk);
        ack_valid = 1'b1; ack64 = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0; ack64 = 1'b0;
        chk(refetch_valid == 1'b0, "R10 accepted no refetch", 64'(refetch_valid), 64'd0);

        // R10: nothing armed (not quadword aligned) -> ack ignored
        send(VECS[1], 1'b1);
        @(negedge clk);
        ack_valid = 1'b1; ack64 = 1'b0;
        @(negedge clk);
        ack_valid = 1'b0;
        chk(refetch_valid == 1'b0, "R10 unarmed no refetch", 64'(refetch_valid), 64'd0);

        // R11: ack for older request in same cycle as hand-over of newer one
        va = VECS[3]; va.addr = 32'h0000_2000; va.lim = 32'h0000_2040; va.dw = 30'd16;
        vb = VECS[2]; vb.addr = 32'h0000_3010; vb.lim = 32'h0000_3040; vb.dw = 30'd12;
        send(va, 1'b1);
        check_rsp(va, 200);
        send(vb, 1'b0);
        check_rsp(vb, 201);
        ack_valid = 1'b1; ack64 = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        chk(refetch_valid == 1'b1, "R11 older refetch", 64'(refetch_valid), 64'd1);
        chk(refetch_addr == 32'h0000_2004, "R11 older addr", 64'(refetch_addr), 64'h2004);
        ack_valid = 1'b1;
        @(negedge clk);
        ack_valid = 1'b0;
        chk(refetch_valid == 1'b1, "R11 newer still armed", 64'(refetch_valid), 64'd1);
        chk(refetch_addr == 32'h0000_3014, "R11 newer addr", 64'(refetch_addr), 64'h3014);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule